// File: doc/BRIEF.md
# Paged Open-Drain Port Register Bank

This block is the host-side register window for six 8-bit open-drain I/O ports. A host reaches it through a single-cycle read/write strobe interface with a byte address. The block claims a 16-byte window whose base is a parameter aligned to 16 bytes. The first six offsets hold port data. A set bit turns on a pin's low-side driver. A clear bit lets the pin float, and an external pull-up takes it high. Reading a port returns the pad level inverted, so a pin pulled low reads as 1.

Offset 7 is a combined control byte. Its top two bits pick a page, and its low six bits are per-port write locks. The three paged offsets (8, 9, 0Ah) give the host access to the edge-detection logic of ports 0 to 2, which sits outside this block:
- page 1 holds the polarity bytes;
- page 2 holds the enable bytes;
- page 3 shows the identification flags, and a write there clears them through a strobe.

Offset 6 reads a per-port summary of the identification flags.

Top module: `odport_regbank`

## Requirements
- R1: After reset every port data bit is 0 (all pins released), the page is 0, all locks are clear, polarity and enable storage are 0, and the read data is 0.
- R2: A write to offset 0 to 5 stores the byte in that port's data register on any page; bit b of port p drives `pin_drive_low[8p+b]`, and 1 means the low-side driver is on.
- R3: A read of offset 0 to 5 returns, on the cycle after the read strobe, the inverse of the pad levels of that port as sampled at the strobe edge.
- R4: A read of offset 6 returns in bit p (p = 0..2) the OR of the eight identification flags of port p, with bits 7:3 at 0; writes to offset 6 are ignored.
- R5: Offset 7 reads back as {page[1:0], lock[5:0]}; page 0 = no paged registers, 1 = polarity, 2 = enable, 3 = identification.
- R6: While lock bit p is 1, writes to port p's data register leave it unchanged; a write to offset 7 always takes effect, even with all locks set.
- R7: On page 1, offsets 8/9/0Ah are read/write polarity bytes for ports 0/1/2 (1 = rising edge); on page 2 they are the enable bytes. Both drive the outputs `evt_pol` and `evt_ena`, port p at bits 8p+7:8p.
- R8: On page 3, offsets 8/9/0Ah read the identification flags of ports 0/1/2. A write there raises `evt_clr[p]` for the cycle of the strobe only, whatever the data, and changes no polarity or enable byte.
- R9: Reads of offsets 0Bh to 0Fh, and of 8 to 0Ah on page 0, return 0; writes to them change no state.
- R10: Accesses whose address lies outside the window change no state and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after the read strobe, 0 otherwise |
| pin_level | input | 48 | Pad levels of the 48 pins |
| pin_drive_low | output | 48 | Low-side driver enables |
| evt_pol | output | 24 | Polarity bytes for ports 0 to 2 |
| evt_ena | output | 24 | Enable bytes for ports 0 to 2 |
| evt_flags | input | 24 | Identification flags from the edge logic |
| evt_clr | output | 3 | Per-port clear strobes for the identification flags |

## Verification
The bench writes to paged offsets while page 0 is selected, then goes back to page 1 and reads the polarity bytes. A decoder that ignored the page would have overwritten them. It sets a lock and writes to the locked port; a design that gated the wrong port, or also gated the page/lock register, would either take the write or leave the locks stuck on. It pulls a released pin low from outside, which exposes any mix-up between the driven value and the pad level or any missing inversion. It also writes to the identification offset with nonzero data, which catches a strobe that fires for the wrong port, lasts two cycles, or disturbs the polarity storage.

// File: rtl/pbank_pkg.sv
package pbank_pkg;
    localparam int PORT_W  = 8;
    localparam int N_PORTS = 6;
    localparam int N_EV    = 3;
    localparam int WIN_LSB = 4;

    localparam logic [3:0] OFF_PEND = 4'h6;
    localparam logic [3:0] OFF_CTL  = 4'h7;
    localparam logic [3:0] OFF_EV0  = 4'h8;
    localparam logic [3:0] OFF_FREE = 4'hB;

    typedef enum logic [1:0] {
        PG_PLAIN = 2'd0,
        PG_POL   = 2'd1,
        PG_ENA   = 2'd2,
        PG_ID    = 2'd3
    } page_e;

    typedef struct packed {
        logic [N_PORTS-1:0][PORT_W-1:0] data;
    } port_st_t;

    typedef struct packed {
        page_e                        page;
        logic [N_PORTS-1:0]           lock;
        logic [N_EV-1:0][PORT_W-1:0]  pol;
        logic [N_EV-1:0][PORT_W-1:0]  ena;
    } ctl_st_t;

    typedef struct packed {
        logic [PORT_W-1:0] rdata;
    } rd_st_t;
endpackage

// File: rtl/pbank_decode.sv
module pbank_decode
    import pbank_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  page_e             page,
    input  logic [N_PORTS-1:0] lock,
    output logic [N_PORTS-1:0] port_we,
    output logic              ctl_we,
    output logic [N_EV-1:0]   pol_we,
    output logic [N_EV-1:0]   ena_we,
    output logic [N_EV-1:0]   id_clr,
    output logic              rd_hit,
    output logic [3:0]        rd_off
);
    logic       in_win;
    logic [3:0] off;
    logic       wr_hit;

    always_comb begin
        in_win = (addr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB]);
        off    = addr[WIN_LSB-1:0];
        wr_hit = wr_en && in_win;
        rd_hit = rd_en && in_win;
        rd_off = off;
        ctl_we = wr_hit && (off == OFF_CTL);
        for (int i = 0; i < N_PORTS; i++) begin
            port_we[i] = wr_hit && (off == 4'(i)) && !lock[i];
        end
        for (int j = 0; j < N_EV; j++) begin
            pol_we[j] = wr_hit && (off == OFF_EV0 + 4'(j)) && (page == PG_POL);
            ena_we[j] = wr_hit && (off == OFF_EV0 + 4'(j)) && (page == PG_ENA);
            id_clr[j] = wr_hit && (off == OFF_EV0 + 4'(j)) && (page == PG_ID);
        end
    end

    // One access touches one identification byte at most.
    assert_clr_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(id_clr));

    // Only one kind of paged storage is written per cycle.
    assert_paged_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({|pol_we, |ena_we, |id_clr}) <= 1);
endmodule

// File: rtl/pbank_ports.sv
module pbank_ports
    import pbank_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_PORTS-1:0]         port_we,
    input  logic [N_PORTS-1:0]         lock,
    input  logic [PORT_W-1:0]          wdata,
    output logic [N_PORTS*PORT_W-1:0]  drive_low
);
    port_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_PORTS; i++) begin
            if (port_we[i]) st_d.data[i] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign drive_low = st_q.data;

    for (genvar g = 0; g < N_PORTS; g++) begin : g_chk
        // A locked port keeps its value across the edge.
        assert_lock_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            lock[g] |=> $stable(st_q.data[g]));
        // An accepted write lands as written.
        assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
            port_we[g] |=> (st_q.data[g] == $past(wdata)));
    end
endmodule

// File: rtl/pbank_ctl.sv
module pbank_ctl
    import pbank_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ctl_we,
    input  logic [N_EV-1:0]          pol_we,
    input  logic [N_EV-1:0]          ena_we,
    input  logic [PORT_W-1:0]        wdata,
    output page_e                    page,
    output logic [N_PORTS-1:0]       lock,
    output logic [N_EV*PORT_W-1:0]   pol,
    output logic [N_EV*PORT_W-1:0]   ena
);
    ctl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctl_we) begin
            st_d.page = page_e'(wdata[PORT_W-1:PORT_W-2]);
            st_d.lock = wdata[N_PORTS-1:0];
        end
        for (int j = 0; j < N_EV; j++) begin
            if (pol_we[j]) st_d.pol[j] = wdata;
            if (ena_we[j]) st_d.ena[j] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign page = st_q.page;
    assign lock = st_q.lock;
    assign pol  = st_q.pol;
    assign ena  = st_q.ena;

    // Reset leaves page 0 and no lock.
    assert_rst_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (st_q.page == PG_PLAIN && st_q.lock == '0));

    // Polarity storage only moves while page 1 is selected.
    assert_pol_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.page != PG_POL) |=> $stable(st_q.pol));

    // Enable storage only moves while page 2 is selected.
    assert_ena_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.page != PG_ENA) |=> $stable(st_q.ena));
endmodule

// File: rtl/pbank_rdmux.sv
module pbank_rdmux
    import pbank_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_hit,
    input  logic [3:0]                 rd_off,
    input  page_e                      page,
    input  logic [N_PORTS-1:0]         lock,
    input  logic [N_EV*PORT_W-1:0]     pol,
    input  logic [N_EV*PORT_W-1:0]     ena,
    input  logic [N_EV*PORT_W-1:0]     flags,
    input  logic [N_PORTS*PORT_W-1:0]  pin_in,
    output logic [PORT_W-1:0]          rdata
);
    rd_st_t            st_d, st_q;
    logic [PORT_W-1:0] val;

    always_comb begin
        val = '0;
        for (int i = 0; i < N_PORTS; i++) begin
            if (rd_off == 4'(i)) val = ~pin_in[i*PORT_W +: PORT_W];
        end
        if (rd_off == OFF_PEND) begin
            for (int j = 0; j < N_EV; j++) val[j] = |flags[j*PORT_W +: PORT_W];
        end
        if (rd_off == OFF_CTL) val = {page, lock};
        for (int j = 0; j < N_EV; j++) begin
            if (rd_off == OFF_EV0 + 4'(j)) begin
                case (page)
                    PG_POL:  val = pol[j*PORT_W +: PORT_W];
                    PG_ENA:  val = ena[j*PORT_W +: PORT_W];
                    PG_ID:   val = flags[j*PORT_W +: PORT_W];
                    default: val = '0;
                endcase
            end
        end
        st_d.rdata = rd_hit ? val : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;

    // Summary byte carries no bits above the three event ports.
    assert_pend_hi_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && rd_off == OFF_PEND) |=> (st_q.rdata[PORT_W-1:N_EV] == '0));

    // Free offsets read as zero.
    assert_free_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && rd_off >= OFF_FREE) |=> (st_q.rdata == '0));
endmodule

// File: rtl/odport_regbank.sv
module odport_regbank
    import pbank_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h200
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [PORT_W-1:0]          bus_wdata,
    output logic [PORT_W-1:0]          bus_rdata,
    input  logic [N_PORTS*PORT_W-1:0]  pin_level,
    output logic [N_PORTS*PORT_W-1:0]  pin_drive_low,
    output logic [N_EV*PORT_W-1:0]     evt_pol,
    output logic [N_EV*PORT_W-1:0]     evt_ena,
    input  logic [N_EV*PORT_W-1:0]     evt_flags,
    output logic [N_EV-1:0]            evt_clr
);
    page_e              page;
    logic [N_PORTS-1:0] lock;
    logic [N_PORTS-1:0] port_we;
    logic               ctl_we;
    logic [N_EV-1:0]    pol_we;
    logic [N_EV-1:0]    ena_we;
    logic               rd_hit;
    logic [3:0]         rd_off;

    pbank_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr_en(bus_wr), .rd_en(bus_rd),
        .page(page), .lock(lock), .port_we(port_we), .ctl_we(ctl_we),
        .pol_we(pol_we), .ena_we(ena_we), .id_clr(evt_clr),
        .rd_hit(rd_hit), .rd_off(rd_off)
    );

    pbank_ports u_ports (
        .clk(clk), .rst_n(rst_n), .port_we(port_we), .lock(lock),
        .wdata(bus_wdata), .drive_low(pin_drive_low)
    );

    pbank_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .pol_we(pol_we), .ena_we(ena_we),
        .wdata(bus_wdata), .page(page), .lock(lock), .pol(evt_pol), .ena(evt_ena)
    );

    pbank_rdmux u_rd (
        .clk(clk), .rst_n(rst_n), .rd_hit(rd_hit), .rd_off(rd_off), .page(page),
        .lock(lock), .pol(evt_pol), .ena(evt_ena), .flags(evt_flags),
        .pin_in(pin_level), .rdata(bus_rdata)
    );

    // A clear strobe never coexists with a polarity or enable write.
    assert_clr_no_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_clr) |=> ($stable(evt_pol) && $stable(evt_ena)));
endmodule

// File: tb/sim_odport_regbank.sv
`timescale 1ns/1ps
module sim_odport_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [47:0] pin_level;
    logic [47:0] pin_drive_low;
    logic [47:0] ext_low = '0;
    logic [23:0] evt_pol, evt_ena;
    logic [23:0] evt_flags = '0;
    logic [2:0]  evt_clr;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // Open-drain pad: low when the block or the outside pulls it low.
    assign pin_level = ~(pin_drive_low | ext_low);

    odport_regbank u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_level(pin_level),
        .pin_drive_low(pin_drive_low), .evt_pol(evt_pol), .evt_ena(evt_ena),
        .evt_flags(evt_flags), .evt_clr(evt_clr)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] a;
        logic [7:0]  d;
        logic [7:0]  e;
        logic [3:0]  r;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h200, 8'hA5, 8'h00, 4'd2},   // R2
        '{1'b0, 12'h200, 8'h00, 8'hA5, 4'd3},   // R3
        '{1'b1, 12'h205, 8'h3C, 8'h00, 4'd2},
        '{1'b0, 12'h205, 8'h00, 8'h3C, 4'd3},
        '{1'b1, 12'h207, 8'h40, 8'h00, 4'd5},   // R5 page 1
        '{1'b0, 12'h207, 8'h00, 8'h40, 4'd5},
        '{1'b1, 12'h208, 8'h81, 8'h00, 4'd7},   // R7
        '{1'b1, 12'h20A, 8'h7E, 8'h00, 4'd7},
        '{1'b0, 12'h208, 8'h00, 8'h81, 4'd7},
        '{1'b0, 12'h20A, 8'h00, 8'h7E, 4'd7},
        '{1'b1, 12'h207, 8'h80, 8'h00, 4'd5},   // page 2
        '{1'b1, 12'h209, 8'hF0, 8'h00, 4'd7},
        '{1'b0, 12'h209, 8'h00, 8'hF0, 4'd7},
        '{1'b0, 12'h208, 8'h00, 8'h00, 4'd7},
        '{1'b1, 12'h207, 8'h00, 8'h00, 4'd5},   // page 0
        '{1'b0, 12'h208, 8'h00, 8'h00, 4'd9},   // R9
        '{1'b1, 12'h208, 8'hFF, 8'h00, 4'd9},
        '{1'b1, 12'h207, 8'h40, 8'h00, 4'd5},
        '{1'b0, 12'h208, 8'h00, 8'h81, 4'd9},
        '{1'b0, 12'h20B, 8'h00, 8'h00, 4'd9},
        '{1'b1, 12'h207, 8'h01, 8'h00, 4'd6},   // R6 lock port 0
        '{1'b1, 12'h200, 8'hFF, 8'h00, 4'd6},
        '{1'b0, 12'h200, 8'h00, 8'hA5, 4'd6},
        '{1'b0, 12'h207, 8'h00, 8'h01, 4'd6},
        '{1'b1, 12'h207, 8'h00, 8'h00, 4'd6},
        '{1'b1, 12'h200, 8'h00, 8'h00, 4'd6},
        '{1'b0, 12'h200, 8'h00, 8'h00, 4'd6},
        '{1'b1, 12'h300, 8'hFF, 8'h00, 4'd10},  // R10
        '{1'b0, 12'h201, 8'h00, 8'h00, 4'd10},
        '{1'b0, 12'h300, 8'h00, 8'h00, 4'd10},
        '{1'b1, 12'h206, 8'hFF, 8'h00, 4'd4},   // R4
        '{1'b0, 12'h206, 8'h00, 8'h00, 4'd4},
        '{1'b1, 12'h20F, 8'h12, 8'h00, 4'd9},
        '{1'b0, 12'h20F, 8'h00, 8'h00, 4'd9}
    };

    task automatic chk(input logic [47:0] got, input logic [47:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(pin_drive_low, 48'h0, "R1 drive");
        chk({evt_pol, evt_ena}, 48'h0, "R1 pol/ena");
        chk(bus_rdata, 8'h00, "R1 rdata");
        rst_n = 1'b1;
        bus_read(12'h207, rd);
        chk(rd, 8'h00, "R1 page/lock");

        for (int k = 0; k < NV; k++) begin
            if (VECS[k].wr) begin
                bus_write(VECS[k].a, VECS[k].d);
            end else begin
                bus_read(VECS[k].a, rd);
                chk(rd, VECS[k].e, $sformatf("R%0d vector %0d", VECS[k].r, k));
            end
        end

        // R2: driver enables follow the data registers
        chk(pin_drive_low, {8'h3C, 40'h0}, "R2 drive map");

        // R3: external pull-down shows up inverted
        ext_low[9] = 1'b1;
        bus_read(12'h201, rd);
        chk(rd, 8'h02, "R3 external low");
        ext_low[9] = 1'b0;
        bus_read(12'h201, rd);
        chk(rd, 8'h00, "R3 released");

        // R7: storage reaches the outputs
        chk(evt_pol, 24'h7E0081, "R7 pol out");
        chk(evt_ena, 24'h00F000, "R7 ena out");

        // R4 and R8: flags, summary, clear strobe
        evt_flags = 24'h004000;
        bus_read(12'h206, rd);
        chk(rd, 8'h02, "R4 summary");
        bus_write(12'h207, 8'hC0);
        bus_read(12'h209, rd);
        chk(rd, 8'h40, "R8 id read");
        @(negedge clk);
        bus_addr = 12'h20A; bus_wdata = 8'h55; bus_wr = 1'b1;
        #1;
        chk(evt_clr, 3'b100, "R8 clear strobe");
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
        chk(evt_clr, 3'b000, "R8 strobe ends");
        chk(evt_pol, 24'h7E0081, "R8 pol untouched");
        evt_flags = '0;

        // R6: all locks set, page/lock still writable
        bus_write(12'h207, 8'h3F);
        bus_write(12'h203, 8'hFF);
        bus_read(12'h203, rd);
        chk(rd, 8'h00, "R6 all locked");
        bus_write(12'h207, 8'h00);
        bus_read(12'h207, rd);
        chk(rd, 8'h00, "R6 unlock");
        bus_write(12'h203, 8'h11);
        bus_read(12'h203, rd);
        chk(rd, 8'h11, "R6 write after unlock");

        // R1: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(pin_drive_low, 48'h0, "R1 re-reset drive");
        chk({evt_pol, evt_ena}, 48'h0, "R1 re-reset storage");
        rst_n = 1'b1;
        bus_read(12'h207, rd);
        chk(rd, 8'h00, "R1 re-reset page/lock");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule